// File: doc/BRIEF.md
# SDRAM Controller Configuration Register File

This block is the configuration and status register set of an SDRAM controller. Software reaches it through two port locations: one holds an internal register offset, the other is a data window onto whichever register that offset selects. Behind the window sit error status, error address, configuration, a read-only status register, refresh and power-management timers, a timing register, ECC configuration and ECC error status, and one configuration register per memory bank.

Every register applies its own write mask. Turning the controller on or off through the configuration register updates the status register and the mapping of every bank at once. The block drives an interrupt while the ECC error status is nonzero. For each bank it exports the decoded base address, the size in bytes and a mapped flag, which downstream address decoding uses. The SDRAM command sequencing lives elsewhere.

Top module: `sdram_cfg_regs`

## Requirements
- R1: A write with `regSel`=0 loads the internal offset register from `regWdata[7:0]`. Reading with `regSel`=0 returns that offset zero-extended. A write with `regSel`=1 targets the register at the held offset, and reading with `regSel`=1 returns it. The error address register (offset 0x10) stores the full written word.
- R2: After reset, the registers read as follows: configuration (0x20) reads 0x00800000, refresh timer (0x30) reads 0x05F00000, power-management timer (0x34) reads 0x07C00000 and timing (0x80) reads 0x00854009. Every other register reads zero, no bank is mapped and the ECC interrupt is low.
- R3: The refresh timer keeps the written bits under 0x3FF80000, timing keeps those under 0x018FC01F and ECC configuration (0x94) keeps those under 0x00F00000. The power-management timer keeps the bits under 0xF8000000 and always has 0x07C00000 set.
- R4: A bank register at offset 0x40 + 4*i stores the written value ANDed with 0xFFDEE001.
- R5: When configuration bit 31 goes from 0 to 1, status bit 31 (offset 0x24) clears. When it goes from 1 to 0, status bit 31 sets. On each transition of configuration bit 30, its new value is copied into status bit 30. Writes to the status register have no effect.
- R6: Bank i is mapped (`bankEn[i]`=1) exactly when its bit 0 and configuration bit 31 are both set. The bank's base is bits 31:23 of its register. Its size is 0x00400000 shifted left by bits 19:17 of its register. These outputs change in the cycle after the write that causes them.
- R7: `eccIrq` rises when the ECC error status (0x98) is written nonzero while it is zero. It stays high while the status is nonzero and falls when zero is written.
- R8: The two error status registers (0x00, 0x08) clear the bits written as 1. Offsets that are not implemented read zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regSel | input | 1 | 0 selects the offset register, 1 selects the data window |
| regWe | input | 1 | Write strobe for the selected location |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data of the selected location |
| eccIrq | output | 1 | ECC error interrupt |
| bankBase | output | 9*NUM_BANKS | Per-bank base address bits 31:23 |
| bankSize | output | 32*NUM_BANKS | Per-bank size in bytes |
| bankEn | output | NUM_BANKS | Per-bank mapped flag |

## Verification
A single configuration write can do two things in the same cycle: it can flip the controller enable and the low-power mirror bit, and through the enable it can remap every enabled bank at once. The bench provokes this by enabling several banks while the controller is off, and then writing configuration bits 31 and 30 together. The following cycle it judges that every enabled bank maps together and that status shows bit 31 cleared and bit 30 set. Assertions check that status bit 31 tracks each enable edge and that no bank is mapped while the controller is off.

// File: rtl/sdram_cfg_pkg.sv
package sdram_cfg_pkg;
  localparam int OFF_W = 8;

  localparam logic [OFF_W-1:0] OFF_ERR0    = 8'h00;
  localparam logic [OFF_W-1:0] OFF_ERR1    = 8'h08;
  localparam logic [OFF_W-1:0] OFF_ERRADDR = 8'h10;
  localparam logic [OFF_W-1:0] OFF_CFG     = 8'h20;
  localparam logic [OFF_W-1:0] OFF_STATUS  = 8'h24;
  localparam logic [OFF_W-1:0] OFF_REFRESH = 8'h30;
  localparam logic [OFF_W-1:0] OFF_POWER   = 8'h34;
  localparam int               OFF_BANK0   = 'h40;
  localparam logic [OFF_W-1:0] OFF_TIMING  = 8'h80;
  localparam logic [OFF_W-1:0] OFF_ECCCFG  = 8'h94;
  localparam logic [OFF_W-1:0] OFF_ECCERR  = 8'h98;

  localparam logic [31:0] MASK_REFRESH = 32'h3FF8_0000;
  localparam logic [31:0] MASK_TIMING  = 32'h018F_C01F;
  localparam logic [31:0] MASK_ECCCFG  = 32'h00F0_0000;
  localparam logic [31:0] MASK_POWER   = 32'hF800_0000;
  localparam logic [31:0] FORCE_POWER  = 32'h07C0_0000;
  localparam logic [31:0] MASK_BANK    = 32'hFFDE_E001;

  localparam logic [31:0] RST_CFG     = 32'h0080_0000;
  localparam logic [31:0] RST_REFRESH = 32'h05F0_0000;
  localparam logic [31:0] RST_POWER   = 32'h07C0_0000;
  localparam logic [31:0] RST_TIMING  = 32'h0085_4009;

  localparam int          BASE_W    = 9;
  localparam logic [31:0] SIZE_UNIT = 32'h0040_0000;

  typedef struct packed {
    logic wrErr0;
    logic wrErr1;
    logic wrErrAddr;
    logic wrCfg;
    logic wrRefresh;
    logic wrPower;
    logic wrTiming;
    logic wrEccCfg;
    logic wrEccErr;
  } strobe_t;
endpackage

// File: rtl/sdram_cfg_ctrl.sv
module sdram_cfg_ctrl
  import sdram_cfg_pkg::*;
#(
  parameter int NUM_BANKS = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regSel,
  input  logic                 regWe,
  input  logic [31:0]          regWdata,
  output logic [OFF_W-1:0]     offsetQ,
  output strobe_t              stb,
  output logic [NUM_BANKS-1:0] bankWr
);
  logic dataWr;
  assign dataWr = regWe & regSel;

  always_ff @(posedge clk) begin
    if (!rstN) offsetQ <= '0;
    else if (regWe && !regSel) offsetQ <= regWdata[OFF_W-1:0];
  end

  always_comb begin
    stb           = '0;
    stb.wrErr0    = dataWr && offsetQ == OFF_ERR0;
    stb.wrErr1    = dataWr && offsetQ == OFF_ERR1;
    stb.wrErrAddr = dataWr && offsetQ == OFF_ERRADDR;
    stb.wrCfg     = dataWr && offsetQ == OFF_CFG;
    stb.wrRefresh = dataWr && offsetQ == OFF_REFRESH;
    stb.wrPower   = dataWr && offsetQ == OFF_POWER;
    stb.wrTiming  = dataWr && offsetQ == OFF_TIMING;
    stb.wrEccCfg  = dataWr && offsetQ == OFF_ECCCFG;
    stb.wrEccErr  = dataWr && offsetQ == OFF_ECCERR;
  end

  for (genvar i = 0; i < NUM_BANKS; i++) begin : gBankStb
    assign bankWr[i] = dataWr && offsetQ == OFF_W'(OFF_BANK0 + 4 * i);
  end
endmodule

// File: rtl/sdram_cfg_dp.sv
module sdram_cfg_dp
  import sdram_cfg_pkg::*;
#(
  parameter int NUM_BANKS = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        regSel,
  input  logic [31:0]                 regWdata,
  input  logic [OFF_W-1:0]            offsetQ,
  input  strobe_t                     stb,
  input  logic [NUM_BANKS-1:0]        bankWr,
  output logic [31:0]                 regRdata,
  output logic                        eccIrq,
  output logic [BASE_W*NUM_BANKS-1:0] bankBase,
  output logic [32*NUM_BANKS-1:0]     bankSize,
  output logic [NUM_BANKS-1:0]        bankEn,
  output logic [31:0]                 cfgQ,
  output logic [31:0]                 statusQ,
  output logic [31:0]                 eccErrQ
);
  logic [31:0] err0Q, err1Q, errAddrQ, refreshQ, powerQ, timingQ, eccCfgQ;
  logic [31:0] bankQ [NUM_BANKS];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      err0Q    <= '0;
      err1Q    <= '0;
      errAddrQ <= '0;
      cfgQ     <= RST_CFG;
      statusQ  <= '0;
      refreshQ <= RST_REFRESH;
      powerQ   <= RST_POWER;
      timingQ  <= RST_TIMING;
      eccCfgQ  <= '0;
      eccErrQ  <= '0;
      eccIrq   <= 1'b0;
    end else begin
      if (stb.wrErr0)    err0Q    <= err0Q & ~regWdata;
      if (stb.wrErr1)    err1Q    <= err1Q & ~regWdata;
      if (stb.wrErrAddr) errAddrQ <= regWdata;
      if (stb.wrRefresh) refreshQ <= regWdata & MASK_REFRESH;
      if (stb.wrPower)   powerQ   <= (regWdata & MASK_POWER) | FORCE_POWER;
      if (stb.wrTiming)  timingQ  <= regWdata & MASK_TIMING;
      if (stb.wrEccCfg)  eccCfgQ  <= regWdata & MASK_ECCCFG;
      if (stb.wrEccErr) begin
        eccErrQ <= regWdata;
        eccIrq  <= |regWdata;
      end
      if (stb.wrCfg) begin
        cfgQ <= regWdata;
        if (!cfgQ[31] && regWdata[31]) statusQ[31] <= 1'b0;
        else if (cfgQ[31] && !regWdata[31]) statusQ[31] <= 1'b1;
        if (cfgQ[30] != regWdata[30]) statusQ[30] <= regWdata[30];
      end
    end
  end

  for (genvar i = 0; i < NUM_BANKS; i++) begin : gBank
    always_ff @(posedge clk) begin
      if (!rstN) bankQ[i] <= '0;
      else if (bankWr[i]) bankQ[i] <= regWdata & MASK_BANK;
    end
    assign bankBase[i*BASE_W +: BASE_W] = bankQ[i][31:23];
    assign bankSize[i*32 +: 32]         = SIZE_UNIT << bankQ[i][19:17];
    assign bankEn[i]                    = bankQ[i][0] & cfgQ[31];
  end

  logic [31:0] windowData;
  always_comb begin
    windowData = '0;
    case (offsetQ)
      OFF_ERR0:    windowData = err0Q;
      OFF_ERR1:    windowData = err1Q;
      OFF_ERRADDR: windowData = errAddrQ;
      OFF_CFG:     windowData = cfgQ;
      OFF_STATUS:  windowData = statusQ;
      OFF_REFRESH: windowData = refreshQ;
      OFF_POWER:   windowData = powerQ;
      OFF_TIMING:  windowData = timingQ;
      OFF_ECCCFG:  windowData = eccCfgQ;
      OFF_ECCERR:  windowData = eccErrQ;
      default:     windowData = '0;
    endcase
    for (int i = 0; i < NUM_BANKS; i++) begin
      if (offsetQ == OFF_W'(OFF_BANK0 + 4 * i)) windowData = bankQ[i];
    end
  end

  assign regRdata = regSel ? windowData : 32'(offsetQ);
endmodule

// File: rtl/sdram_cfg_regs.sv
module sdram_cfg_regs
  import sdram_cfg_pkg::*;
#(
  parameter int NUM_BANKS = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        regSel,
  input  logic                        regWe,
  input  logic [31:0]                 regWdata,
  output logic [31:0]                 regRdata,
  output logic                        eccIrq,
  output logic [BASE_W*NUM_BANKS-1:0] bankBase,
  output logic [32*NUM_BANKS-1:0]     bankSize,
  output logic [NUM_BANKS-1:0]        bankEn
);
  logic [OFF_W-1:0]     offsetQ;
  strobe_t              stb;
  logic [NUM_BANKS-1:0] bankWr;
  logic [31:0]          cfgQ, statusQ, eccErrQ;

  sdram_cfg_ctrl #(.NUM_BANKS(NUM_BANKS)) uCtrl (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWe(regWe),
    .regWdata(regWdata), .offsetQ(offsetQ), .stb(stb), .bankWr(bankWr)
  );

  sdram_cfg_dp #(.NUM_BANKS(NUM_BANKS)) uDp (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWdata(regWdata),
    .offsetQ(offsetQ), .stb(stb), .bankWr(bankWr), .regRdata(regRdata),
    .eccIrq(eccIrq), .bankBase(bankBase), .bankSize(bankSize),
    .bankEn(bankEn), .cfgQ(cfgQ), .statusQ(statusQ), .eccErrQ(eccErrQ)
  );
endmodule

// File: rtl/sdram_cfg_chk.sv
module sdram_cfg_chk #(
  parameter int NUM_BANKS = 4
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [31:0]          cfgQ,
  input logic [31:0]          statusQ,
  input logic [31:0]          eccErrQ,
  input logic                 eccIrq,
  input logic [NUM_BANKS-1:0] bankEn,
  input logic [31:0]          bankSize0
);
  assert_enable_rise_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cfgQ[31]) |-> !statusQ[31]);

  assert_enable_fall_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cfgQ[31]) |-> statusQ[31]);

  assert_status_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    $stable(cfgQ[31:30]) |-> $stable(statusQ[31:30]));

  assert_map_gated_R6: assert property (@(posedge clk) disable iff (!rstN)
    (|bankEn) |-> cfgQ[31]);

  assert_size_pow2_R6: assert property (@(posedge clk) disable iff (!rstN)
    $countones(bankSize0) == 1);

  assert_irq_raise_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(eccErrQ) == 32'd0 && eccErrQ != 32'd0) |-> eccIrq);

  assert_irq_drop_R7: assert property (@(posedge clk) disable iff (!rstN)
    (eccErrQ == 32'd0) |-> !eccIrq);
endmodule

bind sdram_cfg_regs sdram_cfg_chk #(.NUM_BANKS(NUM_BANKS)) uChk (
  .clk(clk), .rstN(rstN), .cfgQ(cfgQ), .statusQ(statusQ),
  .eccErrQ(eccErrQ), .eccIrq(eccIrq), .bankEn(bankEn),
  .bankSize0(bankSize[31:0])
);

// File: tb/sim_sdram_cfg_regs.sv
`timescale 1ns/1ps
module sim_sdram_cfg_regs;
  localparam int NB = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regSel = 1'b0;
  logic regWe = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic eccIrq;
  logic [9*NB-1:0] bankBase;
  logic [32*NB-1:0] bankSize;
  logic [NB-1:0] bankEn;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  sdram_cfg_regs #(.NUM_BANKS(NB)) u0 (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata), .eccIrq(eccIrq),
    .bankBase(bankBase), .bankSize(bankSize), .bankEn(bankEn)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    @(negedge clk);
    regSel = sel; regWe = 1'b1; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic wrReg(input logic [7:0] off, input logic [31:0] d);
    wr(1'b0, 32'(off));
    wr(1'b1, d);
  endtask

  task automatic rdReg(input logic [7:0] off, output logic [31:0] v);
    wr(1'b0, 32'(off));
    regSel = 1'b1;
    #1 v = regRdata;
  endtask

  task automatic testReset();
    logic [31:0] v;
    rdReg(8'h20, v); check("R2 cfg", v, 32'h0080_0000);
    rdReg(8'h30, v); check("R2 refresh", v, 32'h05F0_0000);
    rdReg(8'h34, v); check("R2 power", v, 32'h07C0_0000);
    rdReg(8'h80, v); check("R2 timing", v, 32'h0085_4009);
    rdReg(8'h24, v); check("R2 status", v, 32'h0);
    rdReg(8'h44, v); check("R2 bank1", v, 32'h0);
    check("R2 bankEn", 32'(bankEn), 32'h0);
    check("R2 eccIrq", 32'(eccIrq), 32'h0);
  endtask

  task automatic testIndirect();
    logic [31:0] v;
    wr(1'b0, 32'h0000_0110);
    regSel = 1'b0; #1 check("R1 offset readback", regRdata, 32'h10);
    wr(1'b1, 32'hDEAD_BEEF);
    regSel = 1'b1; #1 check("R1 window readback", regRdata, 32'hDEAD_BEEF);
    rdReg(8'h10, v); check("R1 error address", v, 32'hDEAD_BEEF);
  endtask

  task automatic testMasks();
    logic [31:0] v;
    wrReg(8'h30, 32'hFFFF_FFFF); rdReg(8'h30, v); check("R3 refresh", v, 32'h3FF8_0000);
    wrReg(8'h80, 32'hFFFF_FFFF); rdReg(8'h80, v); check("R3 timing", v, 32'h018F_C01F);
    wrReg(8'h94, 32'hFFFF_FFFF); rdReg(8'h94, v); check("R3 ecc cfg", v, 32'h00F0_0000);
    wrReg(8'h34, 32'h0);         rdReg(8'h34, v); check("R3 power zero", v, 32'h07C0_0000);
    wrReg(8'h34, 32'hFFFF_FFFF); rdReg(8'h34, v); check("R3 power ones", v, 32'hFFC0_0000);
    wrReg(8'h4C, 32'hFFFF_FFFF); rdReg(8'h4C, v); check("R4 bank3 mask", v, 32'hFFDE_E001);
    wrReg(8'h4C, 32'h0);
  endtask

  task automatic testBankMap();
    logic [31:0] v;
    wrReg(8'h44, 32'h0F86_0001);
    check("R6 bank off while ctrl off", 32'(bankEn), 32'h0);
    wrReg(8'h20, 32'h8080_0000);
    check("R6 bank1 mapped", 32'(bankEn), 32'h2);
    check("R6 bank1 base", 32'(bankBase[9 +: 9]), 32'h1F);
    check("R6 bank1 size", bankSize[32 +: 32], 32'h0200_0000);
    rdReg(8'h24, v); check("R5 status after enable", v, 32'h0);
    wrReg(8'h20, 32'h0080_0000);
    check("R6 unmapped on disable", 32'(bankEn), 32'h0);
    rdReg(8'h24, v); check("R5 status after disable", v, 32'h8000_0000);
  endtask

  task automatic testSameCycle();
    logic [31:0] v;
    wrReg(8'h40, 32'h0080_0001);
    wrReg(8'h48, 32'h010A_0001);
    check("R6 still off", 32'(bankEn), 32'h0);
    wrReg(8'h20, 32'hC000_0000);
    check("R6 all mapped together", 32'(bankEn), 32'h7);
    check("R6 bank2 base", 32'(bankBase[18 +: 9]), 32'h2);
    check("R6 bank2 size", bankSize[64 +: 32], 32'h0800_0000);
    check("R6 bank0 size", bankSize[0 +: 32], 32'h0040_0000);
    rdReg(8'h24, v); check("R5 enable with mirror", v, 32'h4000_0000);
  endtask

  task automatic testStatus();
    logic [31:0] v;
    wrReg(8'h20, 32'h8000_0000);
    rdReg(8'h24, v); check("R5 mirror falls", v, 32'h0);
    wrReg(8'h24, 32'hFFFF_FFFF);
    rdReg(8'h24, v); check("R5 status read only", v, 32'h0);
    check("R6 mapping kept", 32'(bankEn), 32'h7);
  endtask

  task automatic testEcc();
    wrReg(8'h98, 32'h5);
    check("R7 irq rises", 32'(eccIrq), 32'h1);
    wrReg(8'h98, 32'h3);
    check("R7 irq held", 32'(eccIrq), 32'h1);
    wrReg(8'h98, 32'h0);
    check("R7 irq falls", 32'(eccIrq), 32'h0);
  endtask

  task automatic testUnused();
    logic [31:0] v;
    wrReg(8'h04, 32'h1234_5678);
    rdReg(8'h04, v); check("R8 unused reads zero", v, 32'h0);
    rdReg(8'h10, v); check("R8 unused write ignored", v, 32'hDEAD_BEEF);
    wrReg(8'h00, 32'hFFFF_FFFF);
    rdReg(8'h00, v); check("R8 error status clear", v, 32'h0);
    wrReg(8'h08, 32'hFFFF_FFFF);
    rdReg(8'h08, v); check("R8 error status 1 clear", v, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testIndirect();
    testMasks();
    testBankMap();
    testSameCycle();
    testStatus();
    testEcc();
    testUnused();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule